// File: doc/BRIEF.md
# Keyed 22 kHz Signalling Carrier with Output Port Steering

This block produces the 22 kHz square-wave carrier that a satellite receiver sends up the coaxial cable to signal the dish electronics, and decides in which cycles that carrier is present. A control bit can hold the carrier on continuously. With that bit clear, a host drives a keying pin with pulse-width-keyed data, and the carrier follows that pin so the host's bit timing is kept. The carrier always starts at once with a high half-period and always ends after a complete low half-period, so gating never produces a short pulse.

A second control bit selects which supply output is live. One is a transmit port that bypasses the line filter and carries both supply and tone. The other is a receive port that feeds the cable through the filter. A master enable puts the whole block in standby: the carrier stops at once and both ports are turned off.

The half-period length is worked out when the design is built, from the system clock rate, rounded to the nearest whole cycle. Elaboration stops if the resulting tone frequency falls outside the allowed band.

Top module: `tone_keyer`

## Requirements
- R1: While `en_i`=1 and `ten_i`=1 the carrier runs without a break, whatever the level on `dsq_i`.
- R2: While `ten_i`=0 the carrier is keyed by `dsq_i` (active high). `dsq_i` passes through a two-flop synchronizer, so a rise on `dsq_i` before clock edge k sets `tone_o` high after edge k+2.
- R3: Each high half and each low half of a running carrier lasts exactly HALF_CNT clock cycles. HALF_CNT is round(CLK_HZ / (2·TONE_HZ)), and the resulting tone frequency lies between 20 kHz and 24 kHz.
- R4: From idle, an active request sets `tone_o` high after the first clock edge at which the request is seen. The carrier starts high.
- R5: When the request is withdrawn, the carrier completes its current period. It only stops after a full low half, and a request that comes back before that low half ends continues the carrier with no change in phase.
- R6: `tx_on_o` and `rx_on_o` are registered. One edge after `en_i`=1 is seen, `tx_on_o` equals `ttx_i` and `rx_on_o` equals its inverse.
- R7: One edge after `en_i`=0 is seen, `tone_o`, `tx_on_o` and `rx_on_o` are all low, even in the middle of a high half.
- R8: While `rst_ni` is low, all three outputs are low.
- R9: A `dsq_i` pulse that lasts a single clock cycle produces exactly one complete carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable; 0 means standby |
| ten_i | input | 1 | Continuous-tone request; overrides keying |
| ttx_i | input | 1 | 1 selects the transmit port, 0 the receive port |
| dsq_i | input | 1 | Asynchronous keying input from the host, active high |
| tone_o | output | 1 | Carrier square wave |
| tx_on_o | output | 1 | Transmit port enable |
| rx_on_o | output | 1 | Receive port enable |

## Verification
The hardest case to reach from the ports is a request that is withdrawn and then restored inside the carrier's final low half. To get there, the bench waits for a falling carrier edge and clears the continuous bit a quarter half-period later. It sets the bit again before the low half ends and checks that the low run is still exactly HALF_CNT cycles. The single-cycle keying pulse and the standby drop in the middle of a high half are driven by the same kind of edge-aligned directed stimulus. The bench uses a reduced clock rate so that a half-period is 40 cycles.

// File: rtl/tone_keyer_pkg.sv
`timescale 1ns/1ps
package tone_keyer_pkg;

   typedef enum logic {
      TK_IDLE = 1'b0,
      TK_RUN  = 1'b1
   } tk_state_e;

   // Half-period length in clock cycles, rounded to the nearest count
   function automatic int unsigned tk_half_count(longint unsigned clk_hz,
                                                 longint unsigned tone_hz);
      return 32'((clk_hz + tone_hz) / (2 * tone_hz));
   endfunction

endpackage

// File: rtl/tk_sync.sv
`timescale 1ns/1ps
module tk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) pipe_q[0] <= 1'b0;
               else         pipe_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) pipe_q[s] <= 1'b0;
               else         pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tk_halfdiv.sv
`timescale 1ns/1ps
module tk_halfdiv #(
   parameter int unsigned HALF = 2,
   localparam int unsigned W   = (HALF > 2) ? $clog2(HALF) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   logic [W-1:0] cnt_q;
   logic         at_end;

   assign at_end = (cnt_q == '0);
   assign tick_o = run_i & at_end;

   // Held at the reload value while idle, so a start is always phase-clean
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= W'(HALF - 1);
      else if (!run_i || at_end)  cnt_q <= W'(HALF - 1);
      else                        cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/tk_carrier.sv
`timescale 1ns/1ps
module tk_carrier
   import tone_keyer_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic req_i,
   input  logic tick_i,
   output logic run_o,
   output logic level_o
);
   tk_state_e state_q;
   logic      level_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= TK_IDLE;
         level_q <= 1'b0;
      end else if (!en_i) begin
         state_q <= TK_IDLE;
         level_q <= 1'b0;
      end else begin
         unique case (state_q)
            TK_IDLE: begin
               if (req_i) begin
                  state_q <= TK_RUN;
                  level_q <= 1'b1;
               end
            end
            TK_RUN: begin
               if (tick_i) begin
                  if (level_q)     level_q <= 1'b0;
                  else if (req_i)  level_q <= 1'b1;
                  else             state_q <= TK_IDLE;
               end
            end
            default: begin
               state_q <= TK_IDLE;
               level_q <= 1'b0;
            end
         endcase
      end
   end

   assign run_o   = (state_q == TK_RUN);
   assign level_o = level_q;
endmodule

// File: rtl/tk_portsel.sv
`timescale 1ns/1ps
module tk_portsel (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic ttx_i,
   output logic tx_on_o,
   output logic rx_on_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_on_o <= 1'b0;
         rx_on_o <= 1'b0;
      end else begin
         tx_on_o <= en_i &  ttx_i;
         rx_on_o <= en_i & ~ttx_i;
      end
   end
endmodule

// File: rtl/tone_keyer.sv
`timescale 1ns/1ps
module tone_keyer
   import tone_keyer_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned TONE_HZ     = 22_000,
   parameter int unsigned TONE_MIN_HZ = 20_000,
   parameter int unsigned TONE_MAX_HZ = 24_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic ten_i,
   input  logic ttx_i,
   input  logic dsq_i,
   output logic tone_o,
   output logic tx_on_o,
   output logic rx_on_o
);
   localparam int unsigned HALF_CNT = tk_half_count(64'(CLK_HZ), 64'(TONE_HZ));
   localparam longint unsigned PERIOD_CLK = 64'(HALF_CNT) * 2;

   // Elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tone_keyer: SYNC_STAGES must be at least 2");
      end
      if (HALF_CNT < 2) begin : g_bad_half
         $error("tone_keyer: clock too slow for the tone");
      end
      if (64'(CLK_HZ) < PERIOD_CLK * 64'(TONE_MIN_HZ) ||
          64'(CLK_HZ) > PERIOD_CLK * 64'(TONE_MAX_HZ)) begin : g_bad_freq
         $error("tone_keyer: rounded tone frequency out of band");
      end
   endgenerate

   logic dsq_s;
   logic req;
   logic run;
   logic tick;

   tk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (dsq_i),
      .q_o   (dsq_s)
   );

   assign req = en_i & (ten_i | dsq_s);

   tk_halfdiv #(.HALF(HALF_CNT)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .tick_o(tick)
   );

   tk_carrier u_car (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .req_i  (req),
      .tick_i (tick),
      .run_o  (run),
      .level_o(tone_o)
   );

   tk_portsel u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .ttx_i  (ttx_i),
      .tx_on_o(tx_on_o),
      .rx_on_o(rx_on_o)
   );
endmodule

// File: rtl/tone_keyer_chk.sv
`timescale 1ns/1ps
module tone_keyer_chk #(
   parameter int unsigned HALF_CNT = 2,
   localparam int unsigned RW      = $clog2(HALF_CNT) + 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic en_i,
   input logic ttx_i,
   input logic tone_o,
   input logic tx_on_o,
   input logic rx_on_o
);
   logic          prev_q;
   logic          en_q;
   logic          armed_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         en_q    <= 1'b0;
         armed_q <= 1'b0;
         run_q   <= '0;
      end else begin
         prev_q <= tone_o;
         en_q   <= en_i;
         if (tone_o != prev_q)  run_q <= RW'(1);
         else if (~&run_q)      run_q <= run_q + 1'b1;
         if (!en_i)                    armed_q <= 1'b0;
         else if (prev_q && !tone_o)   armed_q <= 1'b1;
      end
   end

   // R7: standby forces the carrier low on the next edge
   a_r7_standby_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !tone_o);

   // R7: standby turns both ports off
   a_r7_ports_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!tx_on_o && !rx_on_o));

   // R6: port steering follows the select bit one edge later
   a_r6_port_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> ((tx_on_o == $past(ttx_i)) && (rx_on_o != $past(ttx_i))));

   // R3, R5: a high half ends only after exactly HALF_CNT cycles
   a_r3_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prev_q && !tone_o && en_q) |-> (run_q == RW'(HALF_CNT)));

   // R3, R5: after a normal fall, no low run is shorter than a half period
   a_r5_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!prev_q && tone_o && armed_q) |-> (run_q >= RW'(HALF_CNT)));
endmodule

bind tone_keyer tone_keyer_chk #(.HALF_CNT(HALF_CNT)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_i   (en_i),
   .ttx_i  (ttx_i),
   .tone_o (tone_o),
   .tx_on_o(tx_on_o),
   .rx_on_o(rx_on_o)
);

// File: tb/tone_keyer_tb_top.sv
`timescale 1ns/1ps
module tone_keyer_tb_top;
   localparam int unsigned TB_CLK_HZ = 1_760_000;
   localparam int H = 40;                      // round(1.76e6 / 44e3)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, ten = 1'b0, ttx = 1'b0, dsq = 1'b0;
   logic tone, tx_on, rx_on;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   tone_keyer #(.CLK_HZ(TB_CLK_HZ)) dut_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .en_i   (en),
      .ten_i  (ten),
      .ttx_i  (ttx),
      .dsq_i  (dsq),
      .tone_o (tone),
      .tx_on_o(tx_on),
      .rx_on_o(rx_on)
   );

   // Vector: {en, ten, ttx, dsq, tone_expected, tx_expected, rx_expected}
   localparam logic [6:0] VECS [0:6] = '{
      7'b1110_1_1_0,   // R1 continuous tone ignores idle keying pin
      7'b1010_0_1_0,   // R2 keyed mode, pin low: silent
      7'b1001_1_0_1,   // R2 keyed mode, pin high: carrier
      7'b0111_0_0_0,   // R7 standby overrides everything
      7'b1101_1_0_1,   // R1 override with pin high
      7'b0000_0_0_0,   // R7 standby idle
      7'b1000_0_0_1    // R6 receive port only
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic measure(input int len, output int highs, output int rises);
      logic prev;
      highs = 0;
      rises = 0;
      prev  = tone;
      for (int i = 0; i < len; i++) begin
         step(1);
         if (tone) highs++;
         if (tone && !prev) rises++;
         prev = tone;
      end
   endtask

   task automatic run_len(input logic lvl, output int len);
      len = 1;
      for (int i = 0; i < 8 * H; i++) begin
         step(1);
         if (tone != lvl) break;
         len++;
      end
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      int hi, ri, len;
      logic exp_tone;

      // R8: outputs low under reset, even with everything requested
      en = 1'b1; ten = 1'b1; ttx = 1'b1; dsq = 1'b1;
      step(4);
      chk("R8 tone in reset", int'(tone), 0);
      chk("R8 tx in reset", int'(tx_on), 0);
      chk("R8 rx in reset", int'(rx_on), 0);
      en = 1'b0; ten = 1'b0; ttx = 1'b0; dsq = 1'b0;
      step(1);
      rst_n = 1'b1;
      step(2);

      // Vector table: settle, then one window of four full periods
      for (int v = 0; v < 7; v++) begin
         {en, ten, ttx, dsq} = VECS[v][6:3];
         exp_tone = VECS[v][2];
         step(4 * H + 8);
         measure(8 * H, hi, ri);
         chk($sformatf("R1/R2 vec%0d rises", v), ri, exp_tone ? 4 : 0);
         chk($sformatf("R3 vec%0d high cycles", v), hi, exp_tone ? 4 * H : 0);
         chk($sformatf("R6 vec%0d tx", v), int'(tx_on), int'(VECS[v][1]));
         chk($sformatf("R6 vec%0d rx", v), int'(rx_on), int'(VECS[v][0]));
      end

      // Idle, enabled, keyed mode
      en = 1'b1; ten = 1'b0; ttx = 1'b0; dsq = 1'b0;
      step(4 * H);

      // R4: continuous request starts the carrier after one edge
      ten = 1'b1;
      step(1);
      chk("R4 start latency", int'(tone), 1);
      run_len(1'b1, len);
      chk("R3 high half", len, H);
      run_len(1'b0, len);
      chk("R3 low half", len, H);

      // R5: withdraw inside the final low half and restore before it ends
      run_len(1'b1, len);
      len = 1;
      step(H / 4);
      ten = 1'b0;
      len += H / 4;
      step(H / 4);
      len += H / 4;
      ten = 1'b1;
      for (int i = 0; i < 4 * H; i++) begin
         if (tone) break;
         step(1);
         if (!tone) len++;
      end
      chk("R5 low half kept on restored request", len, H);
      ten = 1'b0;
      step(4 * H);

      // R2: keying pin latency through the synchronizer
      dsq = 1'b1;
      step(2);
      chk("R2 no tone after two edges", int'(tone), 0);
      step(1);
      chk("R2 tone after third edge", int'(tone), 1);
      dsq = 1'b0;
      run_len(1'b1, len);
      chk("R5 high half completes after withdraw", len, H);
      measure(3 * H, hi, ri);
      chk("R5 no restart after withdraw", ri, 0);

      // R9: single-cycle keying pulse yields one whole period
      dsq = 1'b1;
      step(1);
      dsq = 1'b0;
      measure(4 * H, hi, ri);
      chk("R9 pulse rises", ri, 1);
      chk("R9 pulse high cycles", hi, H);

      // R7: standby in the middle of a high half
      ten = 1'b1; ttx = 1'b1;
      step(H / 2);
      chk("R7 running before standby", int'(tone), 1);
      en = 1'b0;
      step(1);
      chk("R7 tone cut at once", int'(tone), 0);
      chk("R7 tx off", int'(tx_on), 0);
      chk("R7 rx off", int'(rx_on), 0);
      measure(2 * H, hi, ri);
      chk("R7 stays silent", hi, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule